// File: doc/BRIEF.md
# Dual-Enable Byte-Wide Static Memory

This block is a clocked model of a byte-wide static memory whose control pins behave like those of an asynchronous part. Two chip enables of opposite sense (`ce1_ni` active low, `ce2_i` active high), an active-low output enable and an active-low write enable are sampled on a fast system clock. Each of them passes through a two-flop stage, and the block then works out whether it is in read, write or deselect mode. The bidirectional data pins are split into an input byte, an output byte and a drive enable. The drive enable is what would turn on the pad drivers.

A write window is open only while the write enable and both chip enables are all active. It therefore opens on whichever of the three edges comes last and closes on whichever comes first. The byte is stored when the window closes, using the address and data held in the last cycle the window was open. A supervisor's power-fail input overrides every other control. While it is high, the block is forced into deselect, and a window that it cuts short is dropped instead of being committed.

The default size is 1024 bytes so the model elaborates quickly. Setting `ADDR_W = 13` gives the full 8K x 8 array.

Top module: `dual_en_sram`

## Requirements
- R1: The block stores 2^ADDR_W bytes. A byte written to one address reads back unchanged later, and writes to other addresses do not disturb it.
- R2: When `we_ni`=1, `ce1_ni`=0, `ce2_i`=1 and `oe_ni`=0, `drive_o` is 1 and `dout_o` holds the byte at `addr_i`. Port changes take effect two clock edges later. With `oe_ni`=1 in the same state, `drive_o` stays 0.
- R3: Whenever `ce1_ni`=1 or `ce2_i`=0, `drive_o` is 0 and no write takes effect, whatever the values of `oe_ni` and `we_ni`.
- R4: A write window is open only while `we_ni`=0, `ce1_ni`=0 and `ce2_i`=1. Exactly one byte is committed per window: the `din_i` value present in the last cycle the window was open. This holds whether the window is ended by `we_ni`, `ce1_ni` or `ce2_i`.
- R5: If the output is being driven and `we_ni` then falls, `drive_o` returns to 0.
- R6: If `we_ni` is already low, or falls together with the chip becoming enabled, `drive_o` never rises during that window, even with `oe_ni`=0.
- R7: While `pfail_i`=1, all control inputs are ignored, `drive_o` is 0 and no byte is written.
- R8: If `pfail_i` rises while a write window is open, that write is discarded. The addressed byte keeps its previous contents, and no other location changes.
- R9: The address stays constant for the whole time a write window is open. This is a usage rule that the bound checker watches.
- R10: `dout_o` is 0 whenever `drive_o` is 0. After reset, `drive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | DATA_W | Write data from the pins |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| pfail_i | input | 1 | Power-fail deselect from a supervisor, active high |
| dout_o | output | DATA_W | Read data, zero when not driven |
| drive_o | output | 1 | Data pin drive enable |

## Verification
On every cycle, the assertions tie `drive_o` to the port controls seen two edges earlier, including the power-fail override. They also check that an undriven bus reads as zero, that commits never come back to back, that no commit happens under power fail, and that the address holds still inside an open window. Whether the correct byte ends up at the correct address can only be shown by the bench's scenarios. The same is true of which edge closes a window, of data that changes partway through a window, and of a write cut short by power fail. The bench shows these by reading the locations back afterwards.

// File: rtl/dual_en_sram_pkg.sv
package dual_en_sram_pkg;
  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic pfail;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // safe state: deselected, supervisor holding the chip off
  localparam ctrl_t CTRL_IDLE = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, pfail: 1'b1};

  typedef enum logic [2:0] {
    MODE_PFAIL = 3'd0,
    MODE_DESEL = 3'd1,
    MODE_IDLE  = 3'd2,
    MODE_READ  = 3'd3,
    MODE_WRITE = 3'd4
  } mode_e;
endpackage

// File: rtl/dual_en_sram_sync.sv
module dual_en_sram_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else         stage_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else         stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dual_en_sram_ctrl.sv
module dual_en_sram_ctrl
  import dual_en_sram_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  output logic  drive_o,
  output logic  wr_open_o,
  output logic  commit_o
);
  mode_e mode;
  logic  wr_q;

  // power fail outranks everything, then either chip enable, then W, then G
  always_comb begin
    if (ctrl_i.pfail)                     mode = MODE_PFAIL;
    else if (ctrl_i.ce1_n || !ctrl_i.ce2) mode = MODE_DESEL;
    else if (!ctrl_i.we_n)                mode = MODE_WRITE;
    else if (!ctrl_i.oe_n)                mode = MODE_READ;
    else                                  mode = MODE_IDLE;
  end

  assign drive_o   = (mode == MODE_READ);
  assign wr_open_o = (mode == MODE_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_open_o;

  // window just closed by an enable edge; a close forced by power fail is dropped
  assign commit_o = wr_q && !wr_open_o && !ctrl_i.pfail;
endmodule

// File: rtl/dual_en_sram_array.sv
module dual_en_sram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem[waddr_i] <= wdata_i;

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/dual_en_sram.sv
module dual_en_sram
  import dual_en_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              pfail_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              drive_o
);
  localparam int BUS_W = ADDR_W + DATA_W;

  ctrl_t             ctrl_raw, ctrl_s;
  logic [BUS_W-1:0]  bus_s;
  logic [ADDR_W-1:0] addr_s, hold_addr;
  logic [DATA_W-1:0] din_s, hold_data, rdata;
  logic              drive, wr_open, commit;

  assign ctrl_raw = '{ce1_n: ce1_ni, ce2: ce2_i, oe_n: oe_ni, we_n: we_ni, pfail: pfail_i};

  dual_en_sram_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
    .clk_i, .rst_ni, .d_i(ctrl_raw), .q_o(ctrl_s)
  );

  // address and data ride the same delay so they stay aligned with the controls
  dual_en_sram_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk_i, .rst_ni, .d_i({addr_i, din_i}), .q_o(bus_s)
  );
  assign {addr_s, din_s} = bus_s;

  dual_en_sram_ctrl u_ctrl (
    .clk_i, .rst_ni, .ctrl_i(ctrl_s),
    .drive_o(drive), .wr_open_o(wr_open), .commit_o(commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_addr <= '0;
      hold_data <= '0;
    end else if (wr_open) begin
      hold_addr <= addr_s;
      hold_data <= din_s;
    end

  dual_en_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .we_i(commit), .waddr_i(hold_addr), .wdata_i(hold_data),
    .raddr_i(addr_s), .rdata_o(rdata)
  );

  assign drive_o = drive;
  assign dout_o  = drive ? rdata : '0;
endmodule

// File: rtl/dual_en_sram_chk.sv
module dual_en_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              pfail_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              drive_o,
  input logic              wr_open,
  input logic              commit,
  input logic [ADDR_W-1:0] addr_s
);
  assert_read_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> ($past(we_ni, 2) && !$past(oe_ni, 2)));

  assert_deselect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o || wr_open) |-> (!$past(ce1_ni, 2) && $past(ce2_i, 2)));

  assert_window_we_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_open |-> !$past(we_ni, 2));

  assert_one_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !commit);

  assert_release_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_open |-> !drive_o);

  assert_pfail_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pfail_i, 2) |-> (!drive_o && !commit && !wr_open));

  assert_addr_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_open && $past(wr_open)) |-> $stable(addr_s));

  assert_idle_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (dout_o == '0));
endmodule

bind dual_en_sram dual_en_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i), .oe_ni(oe_ni),
  .we_ni(we_ni), .pfail_i(pfail_i), .dout_o(dout_o), .drive_o(drive_o),
  .wr_open(wr_open), .commit(commit), .addr_s(addr_s)
);

// File: tb/sim_dual_en_sram.sv
module sim_dual_en_sram;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NWR    = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1, pfail = 1'b0;
  logic [DATA_W-1:0] dout;
  logic drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] model [DEPTH];
  logic [ADDR_W-1:0] wlist [NWR];

  always #(CLK_P/2) clk = ~clk;

  dual_en_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .din_i(din),
    .ce1_ni(ce1_n), .ce2_i(ce2), .oe_ni(oe_n), .we_ni(we_n), .pfail_i(pfail),
    .dout_o(dout), .drive_o(drive)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce1_n = 1'b1; ce2 = 1'b0; oe_n = 1'b1; we_n = 1'b1;
  endtask

  // style 0: W frames the window, 1: E1 frames it, 2: E2 frames it
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int style);
    idle(); addr = a; din = d; step(1);
    case (style)
      0: begin ce1_n = 0; ce2 = 1; step(2); we_n = 0; step(3); we_n = 1; step(1); idle(); end
      1: begin we_n = 0; ce2 = 1; step(1); ce1_n = 0; step(3); ce1_n = 1; step(1); idle(); end
      default: begin we_n = 0; ce1_n = 0; step(1); ce2 = 1; step(3); ce2 = 0; step(1); idle(); end
    endcase
    step(3);
    model[a] = d;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
    addr = a; ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 0; step(3);
    chk({req, " drive"}, 32'(drive), 32'd1);
    chk({req, " data"}, 32'(dout), 32'(model[a]));
    idle(); step(1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    step(3);
    chk("R10 reset drive", 32'(drive), 32'd0);
    chk("R10 reset dout", 32'(dout), 32'd0);
    rst_n = 1'b1;
    step(3);

    // R1 R4: each framing style
    do_write(10'h001, 8'hA5, 0); do_read(10'h001, "R4 W-framed");
    do_write(10'h002, 8'h3C, 1); do_read(10'h002, "R4 E1-framed");
    do_write(10'h003, 8'hC3, 2); do_read(10'h003, "R4 E2-framed");
    do_write(10'h3FF, 8'h7E, 0); do_read(10'h3FF, "R1 top address");
    do_write(10'h000, 8'h81, 1); do_read(10'h000, "R1 bottom address");

    // R2: output enable high keeps bus off
    addr = 10'h001; ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 1; step(3);
    chk("R2 oe high no drive", 32'(drive), 32'd0);
    chk("R10 undriven zero", 32'(dout), 32'd0);
    idle(); step(2);

    // R4: data changes inside window, last value is committed
    addr = 10'h010; din = 8'h11; ce1_n = 0; ce2 = 1; step(2);
    we_n = 0; step(2); din = 8'h22; step(2); din = 8'h33; step(2);
    we_n = 1; step(1); idle(); step(3);
    model[10'h010] = 8'h33;
    do_read(10'h010, "R4 last data in window");

    // R3: deselected writes ignored, no drive
    addr = 10'h001; din = 8'hFF; ce1_n = 1; ce2 = 1; oe_n = 0; we_n = 0; step(4);
    chk("R3 ce1 high no drive", 32'(drive), 32'd0);
    we_n = 1; step(2);
    ce1_n = 0; ce2 = 0; we_n = 0; step(4);
    chk("R3 ce2 low no drive", 32'(drive), 32'd0);
    we_n = 1; idle(); step(3);
    do_read(10'h001, "R3 deselect write ignored");

    // R5: W falls during a driven read, then closes a write
    addr = 10'h020; din = 8'h5A; ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 0; step(3);
    chk("R5 driven before W", 32'(drive), 32'd1);
    we_n = 0; step(3);
    chk("R5 released on W low", 32'(drive), 32'd0);
    we_n = 1; step(1); idle(); step(3);
    model[10'h020] = 8'h5A;
    do_read(10'h020, "R5 write after release");

    // R6: window opens with chip enable, G low throughout
    addr = 10'h030; din = 8'h96; oe_n = 0; we_n = 0; ce2 = 1; step(1);
    ce1_n = 0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R6 never driven", 32'(drive), 32'd0);
    end
    ce2 = 0; step(1); idle(); step(3);
    model[10'h030] = 8'h96;
    do_read(10'h030, "R6 write landed");

    // R7: power fail blocks reads and writes
    pfail = 1; step(1);
    addr = 10'h001; ce1_n = 0; ce2 = 1; oe_n = 0; we_n = 1; step(4);
    chk("R7 no drive in pfail", 32'(drive), 32'd0);
    din = 8'h00; we_n = 0; step(3); we_n = 1; step(1); idle(); step(3);
    pfail = 0; step(3);
    do_read(10'h001, "R7 write blocked");

    // R8: power fail rises inside an open window
    addr = 10'h002; din = 8'hEE; ce1_n = 0; ce2 = 1; step(2);
    we_n = 0; step(3); pfail = 1; step(3);
    we_n = 1; idle(); step(3); pfail = 0; step(3);
    do_read(10'h002, "R8 aborted byte kept");
    do_read(10'h003, "R8 neighbour intact");

    // R1: random writes then read back
    for (int i = 0; i < NWR; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom % DEPTH);
      wlist[i] = a;
      do_write(a, DATA_W'($urandom), int'($urandom % 3));
    end
    for (int i = 0; i < NWR; i += 3) do_read(wlist[i], "R1 random readback");
    for (int i = 0; i < NWR; i += 7) do_read(wlist[i], "R2 random read");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule